// File: doc/BRIEF.md
# Block Sum-of-Absolute-Differences Engine

This engine measures how different two equal-sized pixel blocks are. It walks an index over every pair of matching entries in two arrays of 8-bit samples, such as two 16x16 image tiles. For each pair it takes the absolute value of the difference and adds it to a 32-bit running total. When the walk ends, the total is copied into a separate result register. Both arrays sit outside the block. One address bus and one read enable serve both of them, and the two samples return combinationally in the same cycle.

Control is a five-state machine:
- `ST_IDLE` waits for the start strobe.
- `ST_INIT` clears the running total and the index.
- `ST_CHECK` compares the index with the entry count. It branches to `ST_ACCUM` while the index is lower, and to `ST_FINISH` once it is not.
- `ST_ACCUM` reads one pair, adds its absolute difference and steps the index. It then returns to `ST_CHECK`.
- `ST_FINISH` commits the total to the result register, raises a one-cycle completion pulse and goes back to `ST_IDLE`.

Each element therefore costs two cycles, so a full 256-entry block takes 515 cycles from the start edge to the completion pulse. A start strobe that arrives outside `ST_IDLE` has no effect.

Top module: `sad_engine`

## Requirements
- R1: While reset is low and directly after it, `sad_o` is 0, `done_o` is 0 and `rd_en_o` is 0.
- R2: While the engine is idle and `start_i` is low, `rd_en_o` stays 0 and `done_o` stays 0.
- R3: `rd_en_o` is never high in two consecutive cycles, because every read is followed by a check cycle.
- R4: During a run, the reads present `rd_addr_o` values 0, 1, 2 and so on, each one higher than the last, and there are exactly ENTRIES reads.
- R5: After a run, `sad_o` equals the sum over all entries of |a[i] - b[i]|. The difference of the two unsigned 8-bit samples is taken without overflow for every pair, including 0 against 255 in either direction.
- R6: The completion pulse appears 2*ENTRIES+3 clock edges after the edge that samples `start_i` high in idle (515 edges for 256 entries).
- R7: `done_o` is high for exactly one cycle per run, in the first cycle in which `sad_o` shows the new result.
- R8: `sad_o` changes only in a cycle where `done_o` is high, and otherwise holds its value between runs.
- R9: A start strobe received while a run is in progress is ignored: the result and the latency of that run are unchanged, and no extra run follows.
- R10: Every run starts its total from zero, so a run over identical arrays reports 0 even after a run that reported a nonzero total.
- R11: Whenever `rd_en_o` is high, `rd_addr_o` is below ENTRIES.
- R12: If `start_i` is held high, the idle cycle that shows `done_o` starts the next run, so completion pulses repeat every 2*ENTRIES+4 cycles and each pulse carries a correct total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only in the idle state |
| rd_addr_o | output | 9 | Shared address for both sample arrays |
| rd_en_o | output | 1 | Read enable for both arrays; high in accumulate cycles |
| pix_a_i | input | 8 | Sample returned from array A at `rd_addr_o` |
| pix_b_i | input | 8 | Sample returned from array B at `rd_addr_o` |
| sad_o | output | 32 | Committed sum of absolute differences |
| done_o | output | 1 | One-cycle pulse when `sad_o` has been loaded |

## Verification
The completion of one run and the start of the next can fall in the same cycle. `done_o` is still high in the idle cycle that follows the finish state, and that same idle cycle can sample `start_i`. The bench provokes this overlap by holding `start_i` high across two consecutive runs. It then judges that the completion pulses are exactly 2*ENTRIES+4 cycles apart, that each pulse carries the correct total for the arrays loaded at that moment, and that the strobe present during the finish cycle itself launched nothing.

// File: rtl/sad_pkg.sv
package sad_pkg;

    // Controller states of the engine
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_INIT   = 3'd1,
        ST_CHECK  = 3'd2,
        ST_ACCUM  = 3'd3,
        ST_FINISH = 3'd4
    } sad_state_e;

    // Datapath command bundle issued by the controller
    typedef struct packed {
        logic idx_clr;
        logic idx_inc;
        logic sum_clr;
        logic sum_add;
        logic res_load;
        logic rd_en;
    } sad_cmd_t;

endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
    import sad_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = $clog2(ENTRIES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] idx_i,
    output sad_cmd_t         cmd_o
);

    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(ENTRIES);

    sad_state_e state_q;
    sad_state_e state_d;
    logic       more_left;

    // The index is compared with the entry count only in the check state
    assign more_left = (idx_i < IDX_LIMIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_INIT;
            ST_INIT:   state_d = ST_CHECK;
            ST_CHECK:  state_d = more_left ? ST_ACCUM : ST_FINISH;
            ST_ACCUM:  state_d = ST_CHECK;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Command outputs, decoded from the current state only
    always_comb begin
        cmd_o = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_INIT: begin
                cmd_o.idx_clr = 1'b1;
                cmd_o.sum_clr = 1'b1;
            end
            ST_CHECK: begin
            end
            ST_ACCUM: begin
                cmd_o.rd_en   = 1'b1;
                cmd_o.sum_add = 1'b1;
                cmd_o.idx_inc = 1'b1;
            end
            ST_FINISH: begin
                cmd_o.res_load = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sad_index.sv
module sad_index #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr_i) begin
            idx_q <= '0;
        end else if (inc_i) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] a_i,
    input  logic [PIX_W-1:0] b_i,
    output logic [PIX_W-1:0] mag_o
);

    localparam int DW = PIX_W + 1;

    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] pos;

    // One extra bit of width: every unsigned pair fits as a signed difference
    always_comb begin
        diff  = $signed({1'b0, a_i}) - $signed({1'b0, b_i});
        pos   = diff[DW-1] ? -diff : diff;
        mag_o = pos[PIX_W-1:0];
    end

endmodule

// File: rtl/sad_accum.sv
module sad_accum #(
    parameter int PIX_W = 8,
    parameter int SUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             add_i,
    input  logic             load_i,
    input  logic [PIX_W-1:0] mag_i,
    output logic [SUM_W-1:0] result_o,
    output logic             done_o
);

    localparam int PAD_W = SUM_W - PIX_W;

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] res_q;
    logic             done_q;

    // Running total
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clr_i) begin
            sum_q <= '0;
        end else if (add_i) begin
            sum_q <= sum_q + {{PAD_W{1'b0}}, mag_i};
        end
    end

    // Result register and completion pulse, both loaded on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= load_i;
            if (load_i) begin
                res_q <= sum_q;
            end
        end
    end

    assign result_o = res_q;
    assign done_o   = done_q;

endmodule

// File: rtl/sad_engine.sv
module sad_engine
    import sad_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int ENTRIES = 256,
    parameter int SUM_W   = 32,
    parameter int IDX_W   = $clog2(ENTRIES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [IDX_W-1:0] rd_addr_o,
    output logic             rd_en_o,
    input  logic [PIX_W-1:0] pix_a_i,
    input  logic [PIX_W-1:0] pix_b_i,
    output logic [SUM_W-1:0] sad_o,
    output logic             done_o
);

    sad_cmd_t         cmd;
    logic [IDX_W-1:0] idx;
    logic [PIX_W-1:0] mag;

    sad_ctrl #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .idx_i   (idx),
        .cmd_o   (cmd)
    );

    sad_index #(
        .IDX_W (IDX_W)
    ) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cmd.idx_clr),
        .inc_i (cmd.idx_inc),
        .idx_o (idx)
    );

    sad_absdiff #(
        .PIX_W (PIX_W)
    ) u_absdiff (
        .a_i   (pix_a_i),
        .b_i   (pix_b_i),
        .mag_o (mag)
    );

    sad_accum #(
        .PIX_W (PIX_W),
        .SUM_W (SUM_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cmd.sum_clr),
        .add_i    (cmd.sum_add),
        .load_i   (cmd.res_load),
        .mag_i    (mag),
        .result_o (sad_o),
        .done_o   (done_o)
    );

    assign rd_addr_o = idx;
    assign rd_en_o   = cmd.rd_en;

endmodule

// File: rtl/sad_engine_chk.sv
module sad_engine_chk #(
    parameter int ENTRIES = 256,
    parameter int SUM_W   = 32,
    parameter int IDX_W   = $clog2(ENTRIES) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] rd_addr_o,
    input logic             rd_en_o,
    input logic [SUM_W-1:0] sad_o,
    input logic             done_o
);

    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(ENTRIES);

    // Address the next read of the current run should present
    logic [IDX_W-1:0] exp_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_addr <= '0;
        end else if (done_o) begin
            exp_addr <= '0;
        end else if (rd_en_o) begin
            exp_addr <= exp_addr + IDX_W'(1);
        end
    end

    AST_RD_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o);                                   // R3

    AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (rd_addr_o == exp_addr));                    // R4

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (rd_addr_o < IDX_LIMIT));                    // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                     // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sad_o) |-> done_o);                             // R8

    AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_en_o);                                    // R2

endmodule

bind sad_engine sad_engine_chk #(
    .ENTRIES (ENTRIES),
    .SUM_W   (SUM_W),
    .IDX_W   (IDX_W)
) u_sad_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_o (rd_addr_o),
    .rd_en_o   (rd_en_o),
    .sad_o     (sad_o),
    .done_o    (done_o)
);

// File: tb/sad_engine_tb.sv
module sad_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PIX_W      = 8;
    localparam int ENTRIES    = 256;
    localparam int SUM_W      = 32;
    localparam int IDX_W      = $clog2(ENTRIES) + 1;
    localparam int EXP_LAT    = 2 * ENTRIES + 3;
    localparam int EXP_GAP    = 2 * ENTRIES + 4;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [IDX_W-1:0] rd_addr_o;
    logic             rd_en_o;
    logic [PIX_W-1:0] pix_a_i;
    logic [PIX_W-1:0] pix_b_i;
    logic [SUM_W-1:0] sad_o;
    logic             done_o;

    logic [PIX_W-1:0] mem_a [ENTRIES];
    logic [PIX_W-1:0] mem_b [ENTRIES];

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Arrays with asynchronous read
    assign pix_a_i = (rd_addr_o < IDX_W'(ENTRIES)) ? mem_a[rd_addr_o[IDX_W-2:0]] : '0;
    assign pix_b_i = (rd_addr_o < IDX_W'(ENTRIES)) ? mem_b[rd_addr_o[IDX_W-2:0]] : '0;

    sad_engine #(
        .PIX_W   (PIX_W),
        .ENTRIES (ENTRIES),
        .SUM_W   (SUM_W),
        .IDX_W   (IDX_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rd_addr_o (rd_addr_o),
        .rd_en_o   (rd_en_o),
        .pix_a_i   (pix_a_i),
        .pix_b_i   (pix_b_i),
        .sad_o     (sad_o),
        .done_o    (done_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint expected_sad();
        longint s = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            s += (mem_a[i] >= mem_b[i]) ? longint'(mem_a[i] - mem_b[i])
                                        : longint'(mem_b[i] - mem_a[i]);
        end
        return s;
    endfunction

    // Fill pattern: 0 equal, 1 A max / B zero, 2 A zero / B max, 3 mixed
    task automatic fill(input int pat);
        for (int i = 0; i < ENTRIES; i++) begin
            case (pat)
                0: begin mem_a[i] = PIX_W'(i * 3);   mem_b[i] = PIX_W'(i * 3); end
                1: begin mem_a[i] = '1;              mem_b[i] = '0; end
                2: begin mem_a[i] = '0;              mem_b[i] = '1; end
                default: begin
                    mem_a[i] = PIX_W'(i * 7 + 3);
                    mem_b[i] = PIX_W'((i * 13) ^ 8'h5A);
                end
            endcase
        end
    endtask

    // One run: strobe start, follow the reads, judge latency, total and pulse
    task automatic run_once(input string tag, input int inject_at);
        longint exp_sum = expected_sad();
        int     lat = 0;
        int     n_reads = 0;
        int     addr_err = 0;
        int     alt_err = 0;
        int     range_err = 0;
        bit     prev_en = 1'b0;
        bit     got = 1'b0;
        logic [SUM_W-1:0] held;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int c = 1; c < 4 * ENTRIES; c++) begin
            @(posedge clk); #1;
            start_i = (c == inject_at);
            lat = c;
            if (rd_en_o) begin
                if (prev_en) alt_err++;
                if (rd_addr_o != IDX_W'(n_reads)) addr_err++;
                if (rd_addr_o >= IDX_W'(ENTRIES)) range_err++;
                n_reads++;
            end
            prev_en = rd_en_o;
            if (done_o) begin got = 1'b1; break; end
        end
        start_i = 1'b0;
        check(got && lat == EXP_LAT, {"R6 latency ", tag}, lat, EXP_LAT);
        check(sad_o == SUM_W'(exp_sum), {"R5 total ", tag}, sad_o, exp_sum);
        check(alt_err == 0, {"R3 back-to-back reads ", tag}, alt_err, 0);
        check(addr_err == 0 && n_reads == ENTRIES, {"R4 address order ", tag}, n_reads, ENTRIES);
        check(range_err == 0, {"R11 address range ", tag}, range_err, 0);
        held = sad_o;
        @(posedge clk); #1;
        check(done_o == 1'b0, {"R7 pulse width ", tag}, done_o, 0);
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #1;
            if (rd_en_o || done_o || sad_o != held) begin
                check(1'b0, {"R8 hold after run ", tag}, sad_o, held);
                break;
            end
        end
        check(sad_o == held, {"R8 result held ", tag}, sad_o, held);
    endtask

    task automatic t_reset();
        #1;
        check(sad_o == '0, "R1 sad in reset", sad_o, 0);
        check(done_o == 1'b0, "R1 done in reset", done_o, 0);
        check(rd_en_o == 1'b0, "R1 rd_en in reset", rd_en_o, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(sad_o == '0 && done_o == 1'b0, "R1 after release", sad_o, 0);
    endtask

    task automatic t_idle();
        int busy = 0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); #1;
            if (rd_en_o || done_o) busy++;
        end
        check(busy == 0, "R2 idle without start", busy, 0);
    endtask

    task automatic t_busy_start();
        int extra = 0;
        fill(3);
        run_once("R9 start mid-run", ENTRIES);
        for (int k = 0; k < 3 * ENTRIES; k++) begin
            @(posedge clk); #1;
            if (rd_en_o || done_o) extra++;
        end
        check(extra == 0, "R9 no extra run", extra, 0);
    endtask

    task automatic t_held_start();
        longint s1, s2;
        int gap = 0;
        bit ok1 = 1'b0;
        bit ok2 = 1'b0;
        fill(1);
        s1 = expected_sad();
        @(negedge clk); start_i = 1'b1;
        for (int c = 0; c < 4 * ENTRIES; c++) begin
            @(posedge clk); #1;
            if (done_o) begin ok1 = 1'b1; break; end
        end
        check(ok1 && sad_o == SUM_W'(s1), "R12 first total", sad_o, s1);
        fill(3);
        s2 = expected_sad();
        for (int c = 1; c < 4 * ENTRIES; c++) begin
            @(posedge clk); #1;
            gap = c;
            if (done_o) begin ok2 = 1'b1; start_i = 1'b0; break; end
        end
        start_i = 1'b0;
        check(ok2 && gap == EXP_GAP, "R12 pulse spacing", gap, EXP_GAP);
        check(sad_o == SUM_W'(s2), "R12 second total", sad_o, s2);
        t_idle();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_idle();
        fill(3); run_once("mixed", -1);
        fill(1); run_once("A max B zero", -1);
        fill(2); run_once("A zero B max", -1);
        fill(0); run_once("R10 equal after nonzero", -1);
        check(sad_o == '0, "R10 restart from zero", sad_o, 0);
        t_busy_start();
        t_held_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule